// File: doc/BRIEF.md
# Retriggerable Sprite Pixel Serializer

This block is one hardware sprite channel of a video pipeline. A processor bus writes four small registers: a graphics byte, a horizontal start position, a pixel-width mode and a colour. The channel watches the horizontal beam counter. When the counter reaches the start position, the channel copies the graphics byte into a private shift register and plays it out most significant bit first. Each bit is held for one, two or four pixel clocks.

Each pixel, the channel drives a "sprite on" flag and the current colour. A mixer downstream uses these for priority and compositing. Three properties let software reuse one channel several times on the same scan line:

- The graphics byte is sampled only at a position match.
- A position rewrite acts at once.
- The colour can be changed mid-sprite.

Top module: `spr_channel`

## Requirements
- R1: A synchronous reset clears the graphics, position, width and colour registers and empties the shifter. While the shifter is empty, `pix_on` is 0, and `pix_color` is 0 after reset.
- R2: A write with `wr_en` high selects its register by `wr_addr`: 0 is graphics, 1 is position, 2 is width and 3 is colour. The value takes effect on the pixel clock after the write edge.
- R3: On the first clock where `beam_x` equals the position register, the graphics byte is loaded. Its first pixel appears on the following cycle.
- R4: The loaded byte is shifted out most significant bit first, all 8 bits, and the shifter then goes idle.
- R5: Width code 00 holds each bit 1 pixel, codes 01 and 11 hold it 2 pixels, and code 10 holds it 4 pixels. In 4x mode, byte 0x81 spans 32 pixels, so its first and last lit pixels are 31 apart.
- R6: A width change made while a sprite is drawn takes effect from the next bit boundary.
- R7: Rewriting the graphics register during display leaves the pattern being shifted unchanged. The new byte appears only at the next position match.
- R8: Writing a new position during display takes effect at once. When the beam reaches the new position, the rest of the current pattern is dropped and the new pattern starts there.
- R9: A colour write changes `pix_color` on the next pixel, also partway through a sprite.
- R10: `pix_on` is low whenever the shifter is idle or the current bit is 0.
- R11: A match fires once when the beam and position become equal. It does not fire again while both stay unchanged, for example while the beam counter is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 graphics, 1 position, 2 width, 3 colour) |
| wr_data | input | 8 | Write data |
| beam_x | input | 8 | Horizontal beam counter |
| pix_on | output | 1 | Sprite pixel present this cycle |
| pix_color | output | 8 | Current sprite colour |

## Verification
Every result has a fixed latency:

- A register write is visible one clock after its edge.
- A match loads the shifter at the edge where `beam_x` equals the position register, so the first pixel shows in the next cycle.
- Each later bit follows after 1, 2 or 4 cycles, depending on the width latched at the bit boundary.

The bench keeps a behavioural model that it steps on each rising edge in the same order: match, then shift, then register writes. It compares `pix_on` and `pix_color` with the model at every falling edge, after all registers have settled. Span checks (lit-pixel count, first-to-last distance) are taken from the same falling-edge samples.

// File: rtl/spr_pkg.sv
package spr_pkg;

    parameter int unsigned GFX_BITS   = 8;
    parameter int unsigned BEAM_BITS  = 8;
    parameter int unsigned COLOR_BITS = 8;
    parameter int unsigned BUS_BITS   = 8;

    localparam int unsigned CNT_W = $clog2(GFX_BITS + 1);

    typedef enum logic [1:0] {
        ADDR_GFX = 2'd0,
        ADDR_POS = 2'd1,
        ADDR_WID = 2'd2,
        ADDR_COL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        WID_X1  = 2'b00,
        WID_X2  = 2'b01,
        WID_X4  = 2'b10,
        WID_X2B = 2'b11
    } width_e;

    typedef struct packed {
        logic [GFX_BITS-1:0]   gfx;
        logic [BEAM_BITS-1:0]  pos;
        width_e                wid;
        logic [COLOR_BITS-1:0] col;
    } spr_regs_t;

    typedef struct packed {
        logic                busy;
        logic [GFX_BITS-1:0] pat;
        logic [CNT_W-1:0]    bits_left;
        logic [1:0]          rep_cnt;
        logic [1:0]          rep_max;
    } shift_state_t;

    // Number of extra pixels a bit is held for, by width code.
    function automatic logic [1:0] hold_len_m1(width_e w);
        case (w)
            WID_X1:  return 2'd0;
            WID_X4:  return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/spr_regs.sv
module spr_regs
    import spr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [BUS_BITS-1:0] wr_data,
    output spr_regs_t           regs
);

    spr_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_GFX: regs_q.gfx <= wr_data[GFX_BITS-1:0];
                ADDR_POS: regs_q.pos <= wr_data[BEAM_BITS-1:0];
                ADDR_WID: regs_q.wid <= width_e'(wr_data[1:0]);
                default:  regs_q.col <= wr_data[COLOR_BITS-1:0];
            endcase
        end
    end

    assign regs = regs_q;

    // R9: colour write visible on the next pixel
    p_color_next_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=> (regs.col == $past(wr_data[COLOR_BITS-1:0])));

endmodule

// File: rtl/spr_match.sv
module spr_match
    import spr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BEAM_BITS-1:0] beam_x,
    input  logic [BEAM_BITS-1:0] pos,
    output logic                 fire
);

    logic hit;
    logic hit_d;

    assign hit  = (beam_x == pos);
    assign fire = hit && !hit_d;

    always_ff @(posedge clk) begin
        if (rst) hit_d <= 1'b0;
        else     hit_d <= hit;
    end

    // R11: no second trigger while beam and position are both unchanged
    p_single_fire_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(beam_x) && $stable(pos)) |-> !fire);

endmodule

// File: rtl/spr_shift.sv
module spr_shift
    import spr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [GFX_BITS-1:0] gfx,
    input  width_e              wid,
    output logic                pix_bit
);

    shift_state_t st;
    logic         bit_done;

    assign bit_done = (st.rep_cnt == st.rep_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (fire) begin
            // R8: a new match restarts the shifter, dropping leftover bits
            st.busy      <= 1'b1;
            st.pat       <= gfx;
            st.bits_left <= CNT_W'(GFX_BITS);
            st.rep_cnt   <= 2'd0;
            st.rep_max   <= hold_len_m1(wid);
        end else if (st.busy) begin
            if (bit_done) begin
                st.rep_cnt   <= 2'd0;
                st.pat       <= st.pat << 1;
                st.bits_left <= st.bits_left - 1'b1;
                st.rep_max   <= hold_len_m1(wid);
                if (st.bits_left == CNT_W'(1)) st.busy <= 1'b0;
            end else begin
                st.rep_cnt <= st.rep_cnt + 1'b1;
            end
        end
    end

    assign pix_bit = st.busy && st.pat[GFX_BITS-1];

    // R3: a trigger loads the graphics byte into an active shifter
    p_load_on_match_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> (st.busy && st.pat == $past(gfx)));

    // R4 / R7: without a trigger the pattern only holds or shifts left
    p_shift_only_r4: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !fire) |=> (st.pat == $past(st.pat) || st.pat == ($past(st.pat) << 1)));

    // R6: inside a bit the hold length and pattern stay put
    p_bit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !fire && !bit_done) |=> ($stable(st.rep_max) && $stable(st.pat)));

endmodule

// File: rtl/spr_channel.sv
module spr_channel
    import spr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [BUS_BITS-1:0]   wr_data,
    input  logic [BEAM_BITS-1:0]  beam_x,
    output logic                  pix_on,
    output logic [COLOR_BITS-1:0] pix_color
);

    spr_regs_t regs;
    logic      fire;

    spr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    spr_match u_match (
        .clk    (clk),
        .rst    (rst),
        .beam_x (beam_x),
        .pos    (regs.pos),
        .fire   (fire)
    );

    spr_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .gfx     (regs.gfx),
        .wid     (regs.wid),
        .pix_bit (pix_on)
    );

    assign pix_color = regs.col;

    // R10: no pixel is shown unless a trigger happened since reset
    p_dark_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(fire)) |-> !pix_on);

endmodule

// File: tb/sim_spr_channel.sv
`timescale 1ns/1ps
module sim_spr_channel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] beam_x = 8'd0;
    logic       pix_on;
    logic [7:0] pix_color;

    spr_channel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .beam_x(beam_x), .pix_on(pix_on), .pix_color(pix_color)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit started = 0;
    bit stall = 0;
    bit done = 0;
    int bx = 0;

    // behavioural reference
    int m_gfx = 0, m_pos = 0, m_wid = 0, m_col = 0;
    int m_pat = 0, m_bit = 0, m_left = 0;
    bit m_act = 0, m_hitd = 0;

    function automatic int reps(int w);
        if (w == 0) return 1;
        if (w == 2) return 4;
        return 2;
    endfunction

    always @(posedge clk) begin
        bit hit;
        bit trig;
        hit  = (int'(beam_x) == m_pos);
        trig = hit && !m_hitd;
        m_hitd = hit;
        if (rst) begin
            m_gfx = 0; m_pos = 0; m_wid = 0; m_col = 0;
            m_act = 0; m_hitd = 0; m_pat = 0; m_bit = 0; m_left = 0;
        end else begin
            if (trig) begin
                m_act = 1; m_pat = m_gfx; m_bit = 7; m_left = reps(m_wid);
            end else if (m_act) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_bit == 0) m_act = 0;
                    else begin
                        m_bit--;
                        m_left = reps(m_wid);
                    end
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_gfx = int'(wr_data);
                    2'd1: m_pos = int'(wr_data);
                    2'd2: m_wid = int'(wr_data[1:0]);
                    default: m_col = int'(wr_data);
                endcase
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // measurement of lit pixels
    int on_cnt = 0, first_on = 0, last_on = 0, cyc = 0;

    always @(negedge clk) begin
        if (started && !done) begin
            int exp_on;
            exp_on = (m_act && ((m_pat >> m_bit) & 1)) ? 1 : 0;
            check({phase, " pix_on"}, int'(pix_on), exp_on);
            check({phase, " pix_color"}, int'(pix_color), m_col);
            if (pix_on) begin
                if (on_cnt == 0) first_on = cyc;
                last_on = cyc;
                on_cnt++;
            end
            cyc++;
        end
    end

    task automatic step();
        @(negedge clk);
        if (!stall) bx = (bx + 1) % 256;
        beam_x = 8'(bx);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic clr();
        on_cnt = 0; first_on = 0; last_on = 0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        step(); started = 1;
        step(); step();
        rst = 1'b0;
        // R1: reset state
        check("R1 pix_on after reset", int'(pix_on), 0);
        check("R1 pix_color after reset", int'(pix_color), 0);

        // R2, R3, R4, R10: 1x pattern 0xA5
        phase = "R2/R3/R4/R10";
        wr(3, 8'h3C);
        check("R2 colour register write", int'(pix_color), 8'h3C);
        wr(0, 8'hA5); wr(2, 0);
        clr(); wr(1, (bx + 6) % 256);
        repeat (30) step();
        check("R4 lit count 0xA5", on_cnt, 4);
        check("R4 first-to-last 0xA5", last_on - first_on, 7);
        check("R10 idle after sprite", int'(pix_on), 0);

        // R5: width codes
        phase = "R5";
        wr(0, 8'h81); wr(2, 1);
        clr(); wr(1, (bx + 4) % 256);
        repeat (40) step();
        check("R5 2x (01) span", last_on - first_on, 15);
        check("R5 2x (01) count", on_cnt, 4);
        wr(2, 3);
        clr(); wr(1, (bx + 4) % 256);
        repeat (40) step();
        check("R5 2x (11) span", last_on - first_on, 15);
        wr(2, 2);
        clr(); wr(1, (bx + 4) % 256);
        repeat (50) step();
        check("R5 4x span 0x81", last_on - first_on, 31);
        check("R5 4x count 0x81", on_cnt, 8);

        // R6: width change mid sprite
        phase = "R6";
        wr(0, 8'hFF);
        clr(); wr(1, (bx + 3) % 256);
        repeat (6) step();
        wr(2, 0);
        repeat (40) step();
        check("R6 shortened sprite", (on_cnt > 8 && on_cnt < 32) ? 1 : 0, 1);

        // R7: graphics rewrite mid sprite, new byte at next match
        phase = "R7";
        wr(0, 8'hF0);
        clr(); wr(1, (bx + 3) % 256);
        repeat (4) step();
        wr(0, 8'h0F);
        repeat (20) step();
        check("R7 running pattern kept", on_cnt, 4);
        check("R7 running pattern shape", last_on - first_on, 3);
        clr();
        repeat (260) step();
        check("R7 new byte at next match", on_cnt, 4);

        // R8: position rewrite retriggers
        phase = "R8";
        wr(0, 8'hFF); wr(2, 2);
        clr(); wr(1, (bx + 3) % 256);
        repeat (6) step();
        wr(1, (bx + 4) % 256);
        repeat (50) step();
        check("R8 retrigger lit count", on_cnt, 40);
        check("R8 retrigger span", last_on - first_on, 39);

        // R9: colour change mid sprite
        phase = "R9";
        wr(1, (bx + 3) % 256);
        repeat (8) step();
        wr(3, 8'h55);
        check("R9 colour mid sprite", int'(pix_color), 8'h55);
        check("R9 sprite still lit", int'(pix_on), 1);
        repeat (40) step();

        // R11: stalled beam on the position
        phase = "R11";
        wr(2, 0);
        clr(); wr(1, (bx + 3) % 256);
        step(); step();
        stall = 1;
        repeat (30) step();
        check("R11 single trigger while stalled", on_cnt, 8);
        check("R11 dark after stalled sprite", int'(pix_on), 0);
        stall = 0;
        repeat (4) step();

        finish_up();
    end

endmodule